// File: doc/BRIEF.md
# SPI Register-File Slave

This block lets an external SPI master (mode 0, most significant bit first) read and write a small array of byte-wide registers. Every select period starts with one command byte that carries a register address and a transfer direction, followed by one or two data bytes. A write puts the first data byte into the addressed register and the second into the register after it. A read returns the same two registers, taken as one snapshot. The slave drives its serial output only while it is selected. If a select period carries more bytes than the protocol allows, a flag is set and stays set.

SCLK, MOSI and the active-low select are oversampled in the system clock through synchronizer stages. No separate serial clock domain exists. The register array holds four housekeeping entries followed by two entries per measurement channel. The housekeeping entries are a status byte, a reserved byte and two fixed identification bytes. The channel entries are refreshed from a parallel input word on every cycle. A health input from the surrounding design and the sticky overflow flag make up the status byte.

Top module: `spi_regfile_slave`

## Requirements
- R1: Bits are taken on the rising SCLK edge and the output changes on the falling edge, MSB first. The serial output returns 0x00 while the command byte is shifted in.
- R2: Command bits [3:0] hold the register address. Command bits [7:6] equal to 00 select a write, and any other value selects a read.
- R3: If the command address is not below the register count, the address becomes 0 and the access becomes a read.
- R4: A read returns register[a] and then register[a+1], both captured at the end of the command byte. A position past the last register returns 0x00.
- R5: A write places data byte 1 in register[a] and data byte 2 in register[a+1]. If a+1 is past the end, byte 2 is dropped. Status, reserved and fixed registers ignore writes. A written channel register is overwritten by its refresh on the next cycle.
- R6: Register 1 reads 0x00, register 2 reads 0x12 and register 3 reads 0x34. Channel n takes register 4+2n for its high byte and register 5+2n for its low byte, both taken from bits [16n+15:16n] of the channel word.
- R7: In register 0, bit 7 is 1 when `link_fail` is low, bit 6 is 1 while no overflow has been recorded, and bits 5:0 are 0.
- R8: When a fourth byte completes within one select period, the overflow flag is set. Only reset clears it.
- R9: `miso_oe` is high only while the slave is selected, and `miso_out` is 0 while it is not. A falling select returns the transfer to the command phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low slave select |
| link_fail | input | 1 | High when the upstream link is judged lost |
| ch_word | input | NUM_CH*16 | Per-channel 16-bit measurements, channel 0 in the low bits |
| miso_out | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the external tri-state MISO driver |
| reg_out | output | NUM_REGS*8 | Current register contents, register 0 in the low byte |

## Verification
The bench changes a channel measurement while the first data byte of a read is being shifted. A design that fetched the low byte late would return a torn 16-bit value. A read that starts at the last register must return a zero second byte, and a design with no end guard would wrap around or read stale data. A second instance with fewer channels receives commands for addresses beyond its array. A missing clamp would then return arbitrary data, or would accept a write in place of a status read. The bench also sends a fourth byte in one select period and then reads status twice. This catches a flag that is never set, a flag raised by a legal three-byte transfer, and a flag that clears on the next select.

// File: rtl/spi_rf_pkg.sv
// Package: shared constants and the transfer-phase type of the SPI register slave.
package spi_rf_pkg;
    localparam int BYTE_W     = 8;
    localparam int CMD_ADDR_W = 4;
    localparam int CH_BASE    = 4;
    localparam int IDX_STATUS = 0;
    localparam int IDX_RSVD   = 1;
    localparam int IDX_ID_HI  = 2;
    localparam int IDX_ID_LO  = 3;
    localparam logic [BYTE_W-1:0] ID_HI_VAL = 8'h12;
    localparam logic [BYTE_W-1:0] ID_LO_VAL = 8'h34;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_D1   = 2'd1,
        PH_D2   = 2'd2,
        PH_OVER = 2'd3
    } phase_e;
endpackage

// File: rtl/spi_rf_sync.sv
// Module: multi-bit synchronizer. Each bit passes through STAGES flops.
// Assumes the inputs are independent asynchronous levels. No bus coherency is implied.
module spi_rf_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous level through the stage chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d_async[g]};
        end
        assign d_sync[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_rf_shift.sv
// Module: serial byte engine for SPI mode 0.
// Assumes single-cycle edge strobes from the synchronized SCLK. A load strobe
// places a new byte so that its MSB is on the output before the next rising edge.
module spi_rf_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign byte_done = sel && sclk_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi};
    assign miso      = tx_sh[BYTE_W-1];

    // Receive on rising edges and count bits within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (start) begin
            bit_cnt <= '0;
        end else if (sel && sclk_rise) begin
            rx_sh   <= rx_byte;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Transmit: load a new byte, or shift on a falling edge inside a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tx_sh <= '0;
        else if (start)                          tx_sh <= '0;
        else if (load_en)                        tx_sh <= load_byte;
        else if (sel && sclk_fall && bit_cnt != '0) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
endmodule

// File: rtl/spi_rf_regs.sv
// Module: register array. It holds the status, reserved and fixed ID bytes, and two
// bytes per channel refreshed from the measurement word every cycle.
// Assumes host writes reach only channel entries, and that a refresh replaces them next cycle.
module spi_rf_regs
    import spi_rf_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int NUM_REGS = CH_BASE + 2 * NUM_CH,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       link_fail,
    input  logic                       ovf,
    input  logic [NUM_CH*2*BYTE_W-1:0] ch_word,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat
);
    assign reg_flat[IDX_STATUS*BYTE_W +: BYTE_W] = {~link_fail, ~ovf, {(BYTE_W-2){1'b0}}};
    assign reg_flat[IDX_RSVD*BYTE_W   +: BYTE_W] = '0;
    assign reg_flat[IDX_ID_HI*BYTE_W  +: BYTE_W] = ID_HI_VAL;
    assign reg_flat[IDX_ID_LO*BYTE_W  +: BYTE_W] = ID_LO_VAL;

    for (genvar g = 0; g < 2 * NUM_CH; g++) begin : g_ch
        localparam int SRC_OFS = (g / 2) * 2 * BYTE_W + (((g % 2) == 0) ? BYTE_W : 0);
        localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(CH_BASE + g);
        logic [BYTE_W-1:0] q;
        // Take a host write for one cycle, otherwise refresh from the measurement.
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= '0;
            else if (wr_en && wr_addr == MY_IDX) q <= wr_data;
            else                                 q <= ch_word[SRC_OFS +: BYTE_W];
        end
        assign reg_flat[(CH_BASE+g)*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/spi_regfile_slave.sv
// Module: SPI mode-0 register-file slave (top).
// Assumes the system clock is at least eight times the SCLK rate, so that the synchronizer
// and edge detection finish within one SCLK half period. Clamps the command,
// snapshots reads, and keeps a sticky overflow flag.
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              spi_sclk,
    input  logic                              spi_mosi,
    input  logic                              spi_cs_n,
    input  logic                              link_fail,
    input  logic [NUM_CH*16-1:0]              ch_word,
    output logic                              miso_out,
    output logic                              miso_oe,
    output logic [(CH_BASE+2*NUM_CH)*8-1:0]   reg_out
);
    localparam int NUM_REGS = CH_BASE + 2 * NUM_CH;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    logic [2:0]        pins_s;
    logic              sclk_s, mosi_s, cs_s;
    logic              sclk_d, cs_d;
    logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic              sel_q, ovf_q, rd_q;
    phase_e            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] snap_lo_q;
    logic              byte_done, tx_bit, load_en;
    logic [BYTE_W-1:0] rx_byte, load_byte;
    logic [CMD_ADDR_W-1:0] raw_addr;
    logic              cmd_in_range, dec_rd;
    logic [ADDR_W-1:0] dec_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({spi_cs_n, spi_mosi, spi_sclk}), .d_sync(pins_s)
    );
    assign sclk_s = pins_s[0];
    assign mosi_s = pins_s[1];
    assign cs_s   = pins_s[2];

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~cs_s & cs_d;
    assign cs_rise   = cs_s & ~cs_d;

    spi_rf_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .start(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
        .load_en(load_en), .load_byte(load_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .miso(tx_bit)
    );

    // Return register idx, or zero past the end of the array.
    function automatic logic [BYTE_W-1:0] reg_at(input int idx);
        logic [BYTE_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (k == idx) v = reg_out[k*BYTE_W +: BYTE_W];
        return v;
    endfunction

    // Decode the command byte: address, direction and range clamp.
    always_comb begin
        raw_addr     = rx_byte[CMD_ADDR_W-1:0];
        cmd_in_range = int'(raw_addr) < NUM_REGS;
        dec_addr     = cmd_in_range ? ADDR_W'(raw_addr) : '0;
        dec_rd       = !cmd_in_range || (rx_byte[7:6] != 2'b00);
    end

    // Pick the byte to shift out next, and the write strobe for the current byte.
    always_comb begin
        load_en   = byte_done;
        load_byte = '0;
        wr_en     = 1'b0;
        wr_addr   = addr_q;
        unique case (phase_q)
            PH_CMD:  load_byte = reg_at(int'(dec_addr));
            PH_D1: begin
                load_byte = snap_lo_q;
                wr_en     = byte_done && !rd_q;
            end
            PH_D2: begin
                wr_addr = addr_q + 1'b1;
                wr_en   = byte_done && !rd_q && (int'(addr_q) + 1 < NUM_REGS);
            end
            default: load_byte = '0;
        endcase
    end

    // Transfer control: select tracking, byte phase, command latch, snapshot, overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            phase_q   <= PH_CMD;
            addr_q    <= '0;
            rd_q      <= 1'b1;
            snap_lo_q <= '0;
            ovf_q     <= 1'b0;
        end else if (cs_fall) begin
            sel_q   <= 1'b1;
            phase_q <= PH_CMD;
        end else begin
            if (cs_rise) sel_q <= 1'b0;
            if (byte_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        addr_q    <= dec_addr;
                        rd_q      <= dec_rd;
                        snap_lo_q <= reg_at(int'(dec_addr) + 1);
                        phase_q   <= PH_D1;
                    end
                    PH_D1:   phase_q <= PH_D2;
                    PH_D2:   phase_q <= PH_OVER;
                    default: ovf_q   <= 1'b1;
                endcase
            end
        end
    end

    spi_rf_regs #(.NUM_CH(NUM_CH), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .link_fail(link_fail), .ovf(ovf_q),
        .ch_word(ch_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(rx_byte),
        .reg_flat(reg_out)
    );

    assign miso_oe  = sel_q;
    assign miso_out = sel_q & tx_bit;
endmodule

// File: rtl/spi_rf_checker.sv
// Module: property checker for the SPI register-file slave, bound to every instance.
// Assumes access to the internal synchronized select, phase and command latches.
module spi_rf_checker
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_s,
    input logic                       miso_oe,
    input logic                       miso_out,
    input logic                       ovf_q,
    input logic                       byte_done,
    input phase_e                     phase_q,
    input logic [BYTE_W-1:0]          rx_byte,
    input logic [ADDR_W-1:0]          addr_q,
    input logic                       rd_q,
    input logic                       link_fail,
    input logic [NUM_REGS*BYTE_W-1:0] reg_out
);
    a_r9_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> (!miso_oe && !miso_out));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    a_r8_ovf_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_OVER) |=> ovf_q);

    a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_CMD && int'(rx_byte[CMD_ADDR_W-1:0]) >= NUM_REGS)
        |=> (addr_q == '0 && rd_q));

    a_r2_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_CMD && rx_byte[7:6] == 2'b00
         && int'(rx_byte[CMD_ADDR_W-1:0]) < NUM_REGS) |=> !rd_q);

    a_r6_fixed_ids: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_out[IDX_ID_HI*BYTE_W +: BYTE_W] == ID_HI_VAL)
        && (reg_out[IDX_ID_LO*BYTE_W +: BYTE_W] == ID_LO_VAL)
        && (reg_out[IDX_RSVD*BYTE_W +: BYTE_W] == '0));

    a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_out[7] == !link_fail) && (reg_out[6] == !ovf_q) && (reg_out[5:0] == '0));
endmodule

bind spi_regfile_slave spi_rf_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .miso_oe(miso_oe), .miso_out(miso_out),
    .ovf_q(ovf_q), .byte_done(byte_done), .phase_q(phase_q), .rx_byte(rx_byte),
    .addr_q(addr_q), .rd_q(rd_q), .link_fail(link_fail), .reg_out(reg_out)
);

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;
    localparam int NUM_CH = 6;
    localparam int NR_CH  = 5;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, link_fail = 1'b0;
    logic [NUM_CH*16-1:0] ch_word;
    logic miso_m, oe_m, miso_n, oe_n;
    logic [(4+2*NUM_CH)*8-1:0] regs_m;
    logic [(4+2*NR_CH)*8-1:0]  regs_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rx_m [4];
    logic [7:0] rx_n [4];
    logic       oe_seen;

    always #5 clk = ~clk;

    spi_regfile_slave #(.NUM_CH(NUM_CH)) u_spi_regfile_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .link_fail(link_fail), .ch_word(ch_word), .miso_out(miso_m), .miso_oe(oe_m),
        .reg_out(regs_m)
    );

    spi_regfile_slave #(.NUM_CH(NR_CH)) u_spi_regfile_slave_narrow (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .link_fail(link_fail), .ch_word(ch_word[NR_CH*16-1:0]), .miso_out(miso_n),
        .miso_oe(oe_n), .reg_out(regs_n)
    );

    // {command, expected byte 1, expected byte 2} for reads with 3-byte transfers.
    localparam logic [23:0] RD_VEC [7] = '{
        24'h40_C0_00, 24'h42_12_34, 24'h81_00_12, 24'hC4_05_DC,
        24'h46_03_E8, 24'h4E_07_D0, 24'h4F_D0_00
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift one byte in mode 0 and capture both slaves' MISO before each rising edge.
    task automatic spi_byte(input int slot, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            rx_m[slot][i] = miso_m;
            rx_n[slot][i] = miso_n;
            oe_seen = oe_seen & oe_m;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    // One select period of n bytes. mid_val != 0 changes channel 0 after the command byte.
    task automatic spi_xfer(input int n, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3,
                            input logic [15:0] mid_val);
        logic [7:0] bs [4];
        bs = '{b0, b1, b2, b3};
        oe_seen = 1'b1;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            spi_byte(k, bs[k]);
            if (k == 0 && mid_val != 16'h0) begin
                wait_clk(1);
                ch_word[15:0] = mid_val;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        ch_word = {16'h07D0, 16'h0600, 16'h0500, 16'h0400, 16'h03E8, 16'h05DC};
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // Reset state: R9 released, R6/R7 register contents.
        check(!oe_m && !miso_m, "R9 reset oe", {30'b0, oe_m, miso_m}, 32'h0);
        check(regs_m[7:0] == 8'hC0, "R7 reset status", regs_m[7:0], 32'hC0);
        check(regs_m[31:8] == 24'h34_12_00, "R6 fixed regs", regs_m[31:8], 32'h341200);
        check(regs_m[47:32] == 16'hDC05, "R6 ch0 layout", regs_m[47:32], 32'hDC05);

        // Table of reads (R2 read code, R4 pairs and end guard, R6 map, R1 zero command byte).
        foreach (RD_VEC[i]) begin
            spi_xfer(3, RD_VEC[i][23:16], 8'h00, 8'h00, 8'h00, 16'h0);
            check(rx_m[0] == 8'h00, "R1 command-phase output", rx_m[0], 32'h0);
            check({rx_m[1], rx_m[2]} == RD_VEC[i][15:0], "R4 read pair",
                  {rx_m[1], rx_m[2]}, RD_VEC[i][15:0]);
            check(oe_seen, "R9 oe while selected", oe_seen, 32'h1);
        end

        // R4 snapshot: channel 0 changes during data byte 1.
        spi_xfer(3, 8'h44, 8'h00, 8'h00, 8'h00, 16'h0123);
        check({rx_m[1], rx_m[2]} == 16'h05DC, "R4 snapshot coherent",
              {rx_m[1], rx_m[2]}, 32'h05DC);
        spi_xfer(3, 8'h44, 8'h00, 8'h00, 8'h00, 16'h0);
        check({rx_m[1], rx_m[2]} == 16'h0123, "R4 new value", {rx_m[1], rx_m[2]}, 32'h0123);

        // R5: writes to fixed registers are ignored, and channel writes are refreshed over.
        spi_xfer(3, 8'h02, 8'hAA, 8'hBB, 8'h00, 16'h0);
        spi_xfer(3, 8'h42, 8'h00, 8'h00, 8'h00, 16'h0);
        check({rx_m[1], rx_m[2]} == 16'h1234, "R5 fixed ignores write",
              {rx_m[1], rx_m[2]}, 32'h1234);
        spi_xfer(3, 8'h04, 8'h11, 8'h22, 8'h00, 16'h0);
        spi_xfer(3, 8'h44, 8'h00, 8'h00, 8'h00, 16'h0);
        check({rx_m[1], rx_m[2]} == 16'h0123, "R5 channel refreshed",
              {rx_m[1], rx_m[2]}, 32'h0123);

        // R7: link failure clears status bit 7.
        link_fail = 1'b1;
        spi_xfer(3, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0);
        check(rx_m[1] == 8'h40, "R7 link fail status", rx_m[1], 32'h40);
        link_fail = 1'b0;

        // R3: the narrow slave has 14 registers, so addresses 14 and 15 clamp to a status read.
        spi_xfer(3, 8'h0E, 8'h55, 8'h66, 8'h00, 16'h0);
        check({rx_n[1], rx_n[2]} == 16'hC000, "R3 clamp write to read",
              {rx_n[1], rx_n[2]}, 32'hC000);
        spi_xfer(3, 8'h4F, 8'h00, 8'h00, 8'h00, 16'h0);
        check({rx_n[1], rx_n[2]} == 16'hC000, "R3 clamp read", {rx_n[1], rx_n[2]}, 32'hC000);
        check(regs_n[7:0] == 8'hC0, "R8 no overflow on 3 bytes", regs_n[7:0], 32'hC0);

        // R8: a fourth byte sets the sticky overflow flag.
        spi_xfer(4, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0);
        spi_xfer(3, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0);
        check(rx_m[1] == 8'h80, "R8 overflow flagged", rx_m[1], 32'h80);
        spi_xfer(3, 8'h40, 8'h00, 8'h00, 8'h00, 16'h0);
        check(rx_m[1] == 8'h80, "R8 overflow sticky", rx_m[1], 32'h80);

        // R9: released after deselect.
        check(!oe_m && !oe_n, "R9 released after select", {oe_m, oe_n}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule